// File: doc/BRIEF.md
# Byte-Parallel CRC-32 Frame Engine

This block runs the 32-bit Ethernet-style cyclic redundancy check over a frame, taking one full byte per clock. A combinational network, built by unrolling eight single-bit shift steps of the bit-reflected generator, advances a 32-bit state register once for every accepted byte. A start-of-frame pulse presets the state. An end-of-frame mark on a byte closes the frame.

The frame direction is sampled with start-of-frame. When the frame is transmitted, the engine emits the complemented final state as four check bytes. These follow the last data byte with no gap, so the caller can append them to the outgoing frame. When the frame is received, the caller sends the four received check bytes through the engine as ordinary data, ending with the end-of-frame mark. The engine then compares the final state against the fixed good-frame residue and reports the verdict with a one-cycle done strobe.

Top module: `crc32_frame_engine`

## Requirements
- R1: The generator is 0x04C11DB7, applied in reflected form (0xEDB88320). Bit 0 of each byte is absorbed first. The state is preset to 0xFFFFFFFF. For the ASCII bytes "123456789" the four transmitted check bytes are 0x26, 0x39, 0xF4, 0xCB in that order, which is the complement of the final state.
- R2: A `sof_i` pulse presets the state to all ones. If `byte_vld_i` is high in the same cycle, that byte is absorbed as the first byte of the frame. A `sof_i` alone, followed later by the bytes, gives the same result.
- R3: In a cycle with `byte_vld_i` low and `sof_i` low, the state is unchanged, so idle gaps between bytes do not alter the result.
- R4: In transmit mode (`tx_mode_i`=1 sampled at `sof_i`), `app_vld_o` is high for exactly four consecutive cycles. The first of these cycles is the one right after the clock edge that absorbs the end-of-frame byte. `app_byte_o` carries the complemented state, least significant byte first.
- R5: In receive mode (`tx_mode_i`=0 at `sof_i`), `pass_o` becomes 1 only if the state after the end-of-frame byte equals 0xDEBB20E3, and 0 otherwise. `app_vld_o` stays low throughout a receive frame.
- R6: `done_o` is high for exactly one cycle, the cycle after the edge that absorbs a byte with `eof_i` high. `pass_o` keeps its value until the next `sof_i`, which clears it. An `eof_i` with `byte_vld_i` low has no effect.
- R7: While check bytes are being emitted, `byte_vld_i` and `eof_i` without `sof_i` are ignored: no extra `done_o` is produced and the emitted bytes are not altered. A `sof_i` during emission stops it from the next cycle.
- R8: Synchronous reset `rst` clears `app_vld_o`, `done_o` and `pass_o` and presets the state to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof_i | input | 1 | Start of frame: presets the state and samples the direction |
| tx_mode_i | input | 1 | Frame direction, sampled with `sof_i`: 1 transmit, 0 receive |
| byte_vld_i | input | 1 | `byte_i` holds a frame byte this cycle |
| byte_i | input | 8 | Frame data byte |
| eof_i | input | 1 | Marks the current valid byte as the last of the frame |
| app_vld_o | output | 1 | A check byte to append is present on `app_byte_o` |
| app_byte_o | output | 8 | Complemented check value, least significant byte first |
| done_o | output | 1 | One-cycle strobe after the end-of-frame byte is absorbed |
| pass_o | output | 1 | Receive verdict; held until the next start of frame |

## Verification
The known nine-byte vector pins down the bit order, the preset and the complement. A design with a reversed byte or bit order, or a missing complement, would emit different check bytes. Appending those bytes in a receive frame has to hit the residue, and corrupting a single bit has to miss it, which exposes a wrong residue constant or an inverted verdict. Idle gaps, a separate start-of-frame cycle and a one-byte frame check that the state neither drifts nor loses the first byte. Bytes and end marks injected during emission, an end mark without a valid byte, and a start-of-frame that cuts emission short catch an engine that would raise a spurious done, shift out corrupted bytes, or keep emitting after it has been aborted.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
  localparam int unsigned CRC_WIDTH  = 32;
  localparam int unsigned BYTE_WIDTH = 8;
  localparam logic [CRC_WIDTH-1:0] POLY_REFLECTED = 32'hEDB88320;
  localparam logic [CRC_WIDTH-1:0] PRESET_VALUE   = 32'hFFFFFFFF;
  localparam logic [CRC_WIDTH-1:0] GOOD_RESIDUE   = 32'hDEBB20E3;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } frame_dir_e;
endpackage

// File: rtl/crc32_byte_net.sv
// Unrolled next-state network: DATA_W single-bit shift steps of the
// reflected generator, chained into one combinational function.
module crc32_byte_net #(
  parameter int unsigned CRC_W  = crc32_pkg::CRC_WIDTH,
  parameter int unsigned DATA_W = crc32_pkg::BYTE_WIDTH,
  parameter logic [CRC_W-1:0] POLY = crc32_pkg::POLY_REFLECTED
) (
  input  logic [CRC_W-1:0]  crc_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_o
);
  logic [DATA_W:0][CRC_W-1:0] stage;

  assign stage[0] = crc_i;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_step
      logic fb;
      assign fb = stage[i][0] ^ data_i[i];
      assign stage[i+1] = {1'b0, stage[i][CRC_W-1:1]} ^ ({CRC_W{fb}} & POLY);
    end
  endgenerate

  assign crc_o = stage[DATA_W];
endmodule

// File: rtl/crc32_state.sv
// State register with preset on start of frame and hold on idle cycles.
module crc32_state #(
  parameter int unsigned CRC_W  = crc32_pkg::CRC_WIDTH,
  parameter int unsigned DATA_W = crc32_pkg::BYTE_WIDTH,
  parameter logic [CRC_W-1:0] POLY = crc32_pkg::POLY_REFLECTED,
  parameter logic [CRC_W-1:0] INIT = crc32_pkg::PRESET_VALUE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [CRC_W-1:0]  crc_next_o
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] base;

  assign base = sof_i ? INIT : crc_q;

  crc32_byte_net #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY)
  ) u_net (
    .crc_i (base),
    .data_i(data_i),
    .crc_o (crc_next_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= INIT;
    end else if (take_i) begin
      crc_q <= crc_next_o;
    end else if (sof_i) begin
      crc_q <= INIT;
    end
  end

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!take_i && !sof_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc32_append.sv
// Emits the complemented check value, least significant byte first,
// on consecutive cycles.
module crc32_append #(
  parameter int unsigned CRC_W  = crc32_pkg::CRC_WIDTH,
  parameter int unsigned DATA_W = crc32_pkg::BYTE_WIDTH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [CRC_W-1:0]  final_i,
  input  logic              abort_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] byte_o
);
  localparam int unsigned NUM_BYTES = CRC_W / DATA_W;
  localparam int unsigned IDX_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

  logic [CRC_W-1:0] shift_q;
  logic [IDX_W-1:0] idx_q;
  logic             vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      idx_q   <= '0;
      vld_q   <= 1'b0;
    end else if (load_i) begin
      shift_q <= ~final_i;
      idx_q   <= '0;
      vld_q   <= 1'b1;
    end else if (vld_q) begin
      if (abort_i || idx_q == LAST_IDX) begin
        vld_q <= 1'b0;
      end else begin
        shift_q <= shift_q >> DATA_W;
        idx_q   <= idx_q + 1'b1;
      end
    end
  end

  assign vld_o  = vld_q;
  assign byte_o = shift_q[DATA_W-1:0];

  // R4
  append_len_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(vld_q) && !$past(abort_i)) |-> ($past(idx_q) == LAST_IDX));

  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (abort_i && !load_i) |=> !vld_q);
endmodule

// File: rtl/crc32_frame_engine.sv
module crc32_frame_engine #(
  parameter int unsigned CRC_W  = crc32_pkg::CRC_WIDTH,
  parameter int unsigned DATA_W = crc32_pkg::BYTE_WIDTH,
  parameter logic [CRC_W-1:0] POLY    = crc32_pkg::POLY_REFLECTED,
  parameter logic [CRC_W-1:0] INIT    = crc32_pkg::PRESET_VALUE,
  parameter logic [CRC_W-1:0] RESIDUE = crc32_pkg::GOOD_RESIDUE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof_i,
  input  logic              tx_mode_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              eof_i,
  output logic              app_vld_o,
  output logic [DATA_W-1:0] app_byte_o,
  output logic              done_o,
  output logic              pass_o
);
  import crc32_pkg::*;

  frame_dir_e       dir_q;
  frame_dir_e       dir_eff;
  logic             take;
  logic             last;
  logic [CRC_W-1:0] crc_next;
  logic             done_q;
  logic             pass_q;

  assign dir_eff = sof_i ? frame_dir_e'(tx_mode_i) : dir_q;
  assign take    = byte_vld_i && (sof_i || !app_vld_o);
  assign last    = take && eof_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= DIR_RX;
    end else if (sof_i) begin
      dir_q <= frame_dir_e'(tx_mode_i);
    end
  end

  crc32_state #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W),
    .POLY  (POLY),
    .INIT  (INIT)
  ) u_state (
    .clk       (clk),
    .rst       (rst),
    .sof_i     (sof_i),
    .take_i    (take),
    .data_i    (byte_i),
    .crc_next_o(crc_next)
  );

  crc32_append #(
    .CRC_W (CRC_W),
    .DATA_W(DATA_W)
  ) u_append (
    .clk    (clk),
    .rst    (rst),
    .load_i (last && (dir_eff == DIR_TX)),
    .final_i(crc_next),
    .abort_i(sof_i),
    .vld_o  (app_vld_o),
    .byte_o (app_byte_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      done_q <= last;
      if (last) begin
        pass_q <= (dir_eff == DIR_RX) && (crc_next == RESIDUE);
      end else if (sof_i) begin
        pass_q <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;

  // R4
  done_with_append_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && dir_q == DIR_TX) |-> (app_vld_o && !$past(app_vld_o)));

  // R5
  rx_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_q == DIR_RX && !$past(sof_i)) |-> !$rose(app_vld_o));

  // R6
  pass_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pass_o) |-> done_o);

  // R6
  sof_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (sof_i && !last) |=> !pass_o);
endmodule

// File: tb/crc32_frame_engine_bench.sv
module crc32_frame_engine_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof_i = 1'b0;
  logic       tx_mode_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       eof_i = 1'b0;
  logic       app_vld_o;
  logic [7:0] app_byte_o;
  logic       done_o;
  logic       pass_o;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  crc32_frame_engine u_crc32_frame_engine (
    .clk       (clk),
    .rst       (rst),
    .sof_i     (sof_i),
    .tx_mode_i (tx_mode_i),
    .byte_vld_i(byte_vld_i),
    .byte_i    (byte_i),
    .eof_i     (eof_i),
    .app_vld_o (app_vld_o),
    .app_byte_o(app_byte_o),
    .done_o    (done_o),
    .pass_o    (pass_o)
  );

  // Serial reference model, one bit at a time, LSB first.
  function automatic logic [31:0] ref_update(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int b = 0; b < 8; b++) begin
      if (r[0] ^ d[b]) r = (r >> 1) ^ 32'hEDB88320;
      else             r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Apply one cycle of inputs, then return after the next negedge.
  task automatic step(input bit s, input bit v, input bit e, input logic [7:0] d);
    sof_i = s; byte_vld_i = v; eof_i = e; byte_i = d;
    @(negedge clk);
    sof_i = 1'b0; byte_vld_i = 1'b0; eof_i = 1'b0; byte_i = 8'h00;
  endtask

  logic [7:0] msg [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

  // Collect four appended bytes; the first is already on the port.
  task automatic expect_append(input logic [31:0] crc_final, input string tag);
    logic [31:0] cv;
    cv = ~crc_final;
    for (int k = 0; k < 4; k++) begin
      check(app_vld_o === 1'b1, tag, {31'b0, app_vld_o}, 32'd1);
      check(app_byte_o === cv[8*k +: 8], tag, {24'b0, app_byte_o}, {24'b0, cv[8*k +: 8]});
      if (k == 0) check(done_o === 1'b1, "R6 done with first append", {31'b0, done_o}, 32'd1);
      else        check(done_o === 1'b0, "R6 done single cycle", {31'b0, done_o}, 32'd0);
      step(0, 0, 0, 8'h00);
    end
    check(app_vld_o === 1'b0, {tag, " end"}, {31'b0, app_vld_o}, 32'd0);
  endtask

  task automatic t_reset;
    check(app_vld_o === 1'b0 && done_o === 1'b0 && pass_o === 1'b0, "R8 reset outputs",
          {29'b0, app_vld_o, done_o, pass_o}, 32'd0);
  endtask

  task automatic t_tx_vector;
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    tx_mode_i = 1'b1;
    for (int i = 0; i < 9; i++) begin
      c = ref_update(c, msg[i]);
      step(i == 0, 1, i == 8, msg[i]);
    end
    check(~c === 32'hCBF43926, "R1 known vector model", ~c, 32'hCBF43926);
    check(app_byte_o === 8'h26, "R1 first check byte", {24'b0, app_byte_o}, 32'h26);
    expect_append(c, "R4 tx append");
  endtask

  task automatic t_rx(input bit corrupt, input bit gap_eof);
    logic [7:0] fr [13];
    for (int i = 0; i < 9; i++) fr[i] = msg[i];
    fr[9] = 8'h26; fr[10] = 8'h39; fr[11] = 8'hF4; fr[12] = 8'hCB;
    if (corrupt) fr[4] = fr[4] ^ 8'h10;
    tx_mode_i = 1'b0;
    for (int i = 0; i < 13; i++) begin
      step(i == 0, 1, i == 12, fr[i]);
      if (gap_eof && i == 5) begin
        step(0, 0, 1, 8'hAA);
        check(done_o === 1'b0, "R6 eof without valid ignored", {31'b0, done_o}, 32'd0);
      end
      if (i < 12) check(app_vld_o === 1'b0, "R5 rx no append", {31'b0, app_vld_o}, 32'd0);
    end
    check(done_o === 1'b1, "R6 rx done", {31'b0, done_o}, 32'd1);
    check(pass_o === !corrupt, "R5 rx verdict", {31'b0, pass_o}, {31'b0, !corrupt});
    check(app_vld_o === 1'b0, "R5 rx no append", {31'b0, app_vld_o}, 32'd0);
    step(0, 0, 0, 8'h00);
    check(done_o === 1'b0, "R6 done single cycle", {31'b0, done_o}, 32'd0);
    check(pass_o === !corrupt, "R6 pass held", {31'b0, pass_o}, {31'b0, !corrupt});
    step(1, 0, 0, 8'h00);
    check(pass_o === 1'b0, "R6 sof clears pass", {31'b0, pass_o}, 32'd0);
  endtask

  task automatic t_tx_gaps;
    logic [31:0] c;
    c = 32'hFFFFFFFF;
    tx_mode_i = 1'b1;
    step(1, 0, 0, 8'h00);
    tx_mode_i = 1'b0;
    for (int i = 0; i < 9; i++) begin
      c = ref_update(c, msg[i]);
      step(0, 1, i == 8, msg[i]);
      if (i < 8) for (int g = 0; g < (i % 3); g++) step(0, 0, 0, 8'h5A);
    end
    expect_append(c, "R3 R2 gaps and separate sof");
  endtask

  task automatic t_single_byte;
    logic [31:0] c;
    c = ref_update(32'hFFFFFFFF, 8'h00);
    tx_mode_i = 1'b1;
    step(1, 1, 1, 8'h00);
    expect_append(c, "R2 single byte frame");
  endtask

  task automatic t_ignore_during_append;
    logic [31:0] c, cv;
    c = 32'hFFFFFFFF;
    tx_mode_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      c = ref_update(c, msg[i]);
      step(i == 0, 1, i == 3, msg[i]);
    end
    cv = ~c;
    for (int k = 0; k < 4; k++) begin
      check(app_vld_o === 1'b1 && app_byte_o === cv[8*k +: 8], "R7 bytes during append ignored",
            {23'b0, app_vld_o, app_byte_o}, {23'b0, 1'b1, cv[8*k +: 8]});
      if (k > 0) check(done_o === 1'b0, "R7 eof during append ignored", {31'b0, done_o}, 32'd0);
      step(0, 1, 1, 8'hC3);
    end
    check(app_vld_o === 1'b0 && done_o === 1'b0, "R7 no extra frame",
          {30'b0, app_vld_o, done_o}, 32'd0);
  endtask

  task automatic t_abort;
    tx_mode_i = 1'b1;
    step(1, 1, 0, 8'h11);
    step(0, 1, 1, 8'h22);
    check(app_vld_o === 1'b1, "R4 append starts", {31'b0, app_vld_o}, 32'd1);
    step(0, 0, 0, 8'h00);
    step(1, 0, 0, 8'h00);
    check(app_vld_o === 1'b0, "R7 sof aborts append", {31'b0, app_vld_o}, 32'd0);
    step(0, 0, 0, 8'h00);
    check(app_vld_o === 1'b0, "R7 stays stopped", {31'b0, app_vld_o}, 32'd0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_tx_vector();
        t_rx(0, 0);
        t_rx(1, 0);
        t_rx(0, 1);
        t_tx_gaps();
        t_single_byte();
        t_ignore_during_append();
        t_abort();
        step(1, 0, 0, 8'h00);
        rst = 1'b1;
        step(0, 0, 0, 8'h00);
        rst = 1'b0;
        t_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule